// File: doc/BRIEF.md
# Serial Transmitter Line Control

This block is the line-side control path of a serial transmitter. It turns a stream of bytes into the serial output line (`txd`) and drives an active-low request-to-send pin (`rtsN`) from three control bits: request-to-send, transmit enable and break. Baud-rate generation lives outside the block. The block advances exactly one bit position on each cycle where the `bitTick` enable is high.

In asynchronous mode each byte is sent as a start bit, eight data bits and a stop bit. In synchronous mode bytes are sent back to back with no framing. When no data is waiting, the line carries a fill character (a sync or flag pattern). A one-cycle `crcStart` request queues a two-byte check value, supplied on `crcValue` from an external generator. The check value goes out low byte first, and fill characters follow it.

Software writes bytes into a one-entry holding buffer. A character in flight is never cut short when transmission is disabled. Disabling during a check byte swaps its remaining bits for fill bits. In asynchronous mode, dropping request-to-send takes effect on the pin only after the line has drained.

Top module: `tx_line_ctl`

## Requirements
- R1: After reset `txd` is 1, `rtsN` is 1 and `holdEmpty` is 1.
- R2: In asynchronous mode (`syncMode`=0) a character starts on the first `bitTick` that finds `txEnable` high and the holding buffer full. It is sent one bit per tick as a 0 start bit, then data bits 0 to 7, then a 1 stop bit. The character ends at the tick after the stop bit.
- R3: While no character is in progress and `txEnable` is low, `txd` stays 1 and a held byte is not started.
- R4: Clearing `txEnable` after a character has started does not shorten it. All its bits are sent, and the line then idles at 1.
- R5: While `sendBreak` is high, `txd` is 0 in the same cycle, whatever is being sent. Bit sequencing keeps running underneath. After `sendBreak` is released, `txd` shows the bit that belongs to the current tick position.
- R6: `rtsN` is the inverse of the request-to-send bit `rtsBit`. In asynchronous mode, setting the bit drives `rtsN` low one cycle later.
- R7: In asynchronous mode, after `rtsBit` is cleared, `rtsN` stays low until the character in progress has ended and the holding buffer is empty. It then goes high within two cycles.
- R8: In synchronous mode (`syncMode`=1), `rtsN` follows `rtsBit` combinationally, with no deferral.
- R9: In synchronous mode with `txEnable` high, characters are sent as eight bits, LSB first, with no start or stop bit. Each character follows the previous one with no gap. The next character is chosen in this order: the high check byte if the low one was just sent, then a held data byte, then a pending check request, then the fill character `fillChar`.
- R10: A `crcStart` pulse in synchronous mode causes `crcValue[7:0]` and then `crcValue[15:8]` to be sent once the holding buffer is found empty. Fill characters follow them.
- R11: If `txEnable` is cleared while a check byte is being sent in synchronous mode, the rest of that byte's bit positions carry the matching bits of `fillChar`. No further check byte is sent.
- R12: A `holdLoad` while the holding buffer is full is ignored. The held byte is unchanged and no extra character is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle bit-rate enable |
| syncMode | input | 1 | 0 asynchronous framing, 1 synchronous |
| rtsBit | input | 1 | Request-to-send control bit |
| txEnable | input | 1 | Transmit enable control bit |
| sendBreak | input | 1 | Force line to spacing |
| crcStart | input | 1 | Pulse: queue the check bytes (synchronous only) |
| holdLoad | input | 1 | Write strobe for the holding buffer |
| holdData | input | 8 | Byte written into the holding buffer |
| fillChar | input | 8 | Sync or flag character used as fill |
| crcValue | input | 16 | Check value, low byte sent first |
| holdEmpty | output | 1 | Holding buffer can accept a byte |
| txd | output | 1 | Serial output line, 1 is marking |
| rtsN | output | 1 | Request-to-send pin, active low |

## Verification
The assertions assume that `syncMode` does not change while a character is in progress. They also assume that `crcValue` and `fillChar` stay steady until the bytes taken from them have been fully sent. The stimulus changes the mode only after the line has been idle for several ticks. It sets the check value and fill pattern before enabling transmission.

The random part of the test sends bytes in both modes, with ticks spaced a fixed number of cycles apart. It loads the holding buffer only when `holdEmpty` allows a write, except in the one directed case that writes to a full buffer on purpose.

// File: rtl/tx_line_pkg.sv
package tx_line_pkg;

  typedef enum logic [1:0] {
    CH_DATA   = 2'd0,
    CH_FILL   = 2'd1,
    CH_CRC_LO = 2'd2,
    CH_CRC_HI = 2'd3
  } chKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;   // begin a new character this cycle
    chKind_t kind;   // source of the new character
    logic    abort;  // replace check byte with fill pattern
  } txStrobe_t;

endpackage

// File: rtl/tx_line_ctrl.sv
module tx_line_ctrl
  import tx_line_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             syncMode,
  input  logic             rtsBit,
  input  logic             txEnable,
  input  logic             crcStart,
  input  logic             holdFull,
  output logic             busy,
  output logic [CNT_W-1:0] bitCnt,
  output txStrobe_t        stb,
  output logic             rtsN
);

  localparam logic [CNT_W-1:0] ASYNC_LAST = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] SYNC_LAST  = CNT_W'(DATA_W - 1);

  chKind_t kind, nextKind;
  logic crcPend, rtsHeld;
  logic [CNT_W-1:0] lastIdx;
  logic charDone, canStart, abortCrc, haveWork;

  assign lastIdx  = syncMode ? SYNC_LAST : ASYNC_LAST;
  assign charDone = busy && bitTick && (bitCnt == lastIdx);
  assign haveWork = holdFull || syncMode;
  assign canStart = (!busy || charDone) && bitTick && txEnable && haveWork;
  assign abortCrc = busy && syncMode && !txEnable &&
                    ((kind == CH_CRC_LO) || (kind == CH_CRC_HI));

  always_comb begin
    if (busy && kind == CH_CRC_LO)  nextKind = CH_CRC_HI;
    else if (holdFull)              nextKind = CH_DATA;
    else if (crcPend)               nextKind = CH_CRC_LO;
    else                            nextKind = CH_FILL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      bitCnt  <= '0;
      kind    <= CH_FILL;
      crcPend <= 1'b0;
      rtsHeld <= 1'b0;
    end else begin
      if (canStart) begin
        busy   <= 1'b1;
        bitCnt <= '0;
        kind   <= nextKind;
      end else begin
        if (charDone) busy <= 1'b0;
        if (busy && bitTick) bitCnt <= bitCnt + 1'b1;
        if (abortCrc) kind <= CH_FILL;
      end
      crcPend <= (crcPend && !(canStart && nextKind == CH_CRC_LO)) ||
                 (crcStart && syncMode);
      rtsHeld <= rtsBit || (rtsHeld && (busy || holdFull));
    end
  end

  assign rtsN = syncMode ? ~rtsBit : ~rtsHeld;

  always_comb begin
    stb.load  = canStart;
    stb.kind  = nextKind;
    stb.abort = abortCrc;
  end

  // R7
  rts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rtsHeld && (busy || holdFull)) |=> rtsHeld);

  // R4
  finish_char_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !txEnable && !bitTick) |=> busy);

  // R11
  crc_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && syncMode && !txEnable && kind == CH_CRC_LO) |=> (kind == CH_FILL));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitCnt <= lastIdx));

endmodule

// File: rtl/tx_line_data.sv
module tx_line_data
  import tx_line_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 2),
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncMode,
  input  logic              sendBreak,
  input  logic              holdLoad,
  input  logic [DATA_W-1:0] holdData,
  input  logic [DATA_W-1:0] fillChar,
  input  logic [2*DATA_W-1:0] crcValue,
  input  txStrobe_t         stb,
  input  logic              busy,
  input  logic [CNT_W-1:0]  bitCnt,
  output logic              holdFull,
  output logic              txd
);

  localparam logic [CNT_W-1:0] ASYNC_LAST = CNT_W'(DATA_W + 1);

  logic [DATA_W-1:0] holdByte, curByte, srcByte;
  logic [IDX_W-1:0]  idx;
  logic consume, dataBit, lineBit;

  assign consume = stb.load && (stb.kind == CH_DATA);

  always_comb begin
    unique case (stb.kind)
      CH_DATA:   srcByte = holdByte;
      CH_CRC_LO: srcByte = crcValue[DATA_W-1:0];
      CH_CRC_HI: srcByte = crcValue[2*DATA_W-1:DATA_W];
      default:   srcByte = fillChar;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdByte <= '0;
      curByte  <= '1;
    end else begin
      if (consume) holdFull <= 1'b0;
      else if (holdLoad && !holdFull) begin
        holdFull <= 1'b1;
        holdByte <= holdData;
      end
      if (stb.load)       curByte <= srcByte;
      else if (stb.abort) curByte <= fillChar;
    end
  end

  assign idx     = syncMode ? bitCnt[IDX_W-1:0] : IDX_W'(bitCnt - 1'b1);
  assign dataBit = curByte[idx];

  always_comb begin
    if (syncMode)                  lineBit = dataBit;
    else if (bitCnt == '0)         lineBit = 1'b0;
    else if (bitCnt == ASYNC_LAST) lineBit = 1'b1;
    else                           lineBit = dataBit;
  end

  assign txd = sendBreak ? 1'b0 : (busy ? lineBit : 1'b1);

  // R12
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && holdLoad && !consume) |=> (holdFull && $stable(holdByte)));

endmodule

// File: rtl/tx_line_ctl.sv
module tx_line_ctl
  import tx_line_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 2)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitTick,
  input  logic                syncMode,
  input  logic                rtsBit,
  input  logic                txEnable,
  input  logic                sendBreak,
  input  logic                crcStart,
  input  logic                holdLoad,
  input  logic [DATA_W-1:0]   holdData,
  input  logic [DATA_W-1:0]   fillChar,
  input  logic [2*DATA_W-1:0] crcValue,
  output logic                holdEmpty,
  output logic                txd,
  output logic                rtsN
);

  txStrobe_t        stb;
  logic             busy, holdFull;
  logic [CNT_W-1:0] bitCnt;

  tx_line_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .syncMode(syncMode),
    .rtsBit(rtsBit), .txEnable(txEnable), .crcStart(crcStart),
    .holdFull(holdFull), .busy(busy), .bitCnt(bitCnt), .stb(stb), .rtsN(rtsN)
  );

  tx_line_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .syncMode(syncMode), .sendBreak(sendBreak),
    .holdLoad(holdLoad), .holdData(holdData), .fillChar(fillChar),
    .crcValue(crcValue), .stb(stb), .busy(busy), .bitCnt(bitCnt),
    .holdFull(holdFull), .txd(txd)
  );

  assign holdEmpty = ~holdFull;

endmodule

// File: tb/tx_line_ctl_test.sv
module tx_line_ctl_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic syncMode = 1'b0, rtsBit = 1'b0, txEnable = 1'b0, sendBreak = 1'b0;
  logic crcStart = 1'b0, holdLoad = 1'b0;
  logic [7:0]  holdData = 8'h00;
  logic [7:0]  fillChar = 8'h7E;
  logic [15:0] crcValue = 16'h1234;
  logic holdEmpty, txd, rtsN;

  int checks = 0;
  int errors = 0;
  int tickCnt = 0;

  tx_line_ctl uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .syncMode(syncMode),
    .rtsBit(rtsBit), .txEnable(txEnable), .sendBreak(sendBreak),
    .crcStart(crcStart), .holdLoad(holdLoad), .holdData(holdData),
    .fillChar(fillChar), .crcValue(crcValue), .holdEmpty(holdEmpty),
    .txd(txd), .rtsN(rtsN)
  );

  always #5 clk = ~clk;

  // bit enable every fourth cycle, changed away from the active edge
  always @(negedge clk) begin
    tickCnt <= (tickCnt == 3) ? 0 : tickCnt + 1;
    bitTick <= (tickCnt == 3);
  end

  function automatic logic [9:0] asyncFrame(input logic [7:0] b);
    return {1'b1, b, 1'b0};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nextBit(output logic b);
    forever begin
      @(posedge clk);
      if (bitTick) break;
    end
    @(negedge clk);
    b = txd;
  endtask

  task automatic loadByte(input logic [7:0] v);
    holdData = v;
    holdLoad = 1'b1;
    @(negedge clk);
    holdLoad = 1'b0;
  endtask

  task automatic waitStart(output bit found);
    logic b;
    found = 1'b0;
    for (int i = 0; i < 40; i++) begin
      nextBit(b);
      if (b == 1'b0) begin
        found = 1'b1;
        break;
      end
    end
  endtask

  task automatic idleBits(input int n, output logic allOnes);
    logic b;
    allOnes = 1'b1;
    for (int i = 0; i < n; i++) begin
      nextBit(b);
      if (b !== 1'b1) allOnes = 1'b0;
    end
  endtask

  task automatic syncByte(input int from, inout logic [7:0] v);
    logic b;
    for (int i = from; i < 8; i++) begin
      nextBit(b);
      v[i] = b;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] got;
    logic [7:0] cur, nxt, sb;
    logic ones, b;
    bit found;
    void'($urandom(32'd20240611));

    repeat (5) @(negedge clk);
    // R1 reset state
    check(txd === 1'b1, "R1 txd", txd, 1);
    check(rtsN === 1'b1, "R1 rtsN", rtsN, 1);
    check(holdEmpty === 1'b1, "R1 holdEmpty", holdEmpty, 1);
    rstN = 1'b1;
    @(negedge clk);

    // R6 async assert of request-to-send
    rtsBit = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(rtsN === 1'b0, "R6 rtsN low", rtsN, 0);

    // R2 random asynchronous frames
    txEnable = 1'b1;
    for (int k = 0; k < 16; k++) begin
      cur = 8'($urandom());
      loadByte(cur);
      waitStart(found);
      got = '0;
      for (int i = 1; i < 10; i++) nextBit(got[i]);
      check(found && got == asyncFrame(cur), "R2 async frame", got, asyncFrame(cur));
    end
    idleBits(3, ones);
    check(ones, "R2 idle after frames", ones, 1);

    // R3 disabled: held byte not started
    txEnable = 1'b0;
    loadByte(8'h5A);
    idleBits(12, ones);
    check(ones, "R3 marking while disabled", ones, 1);
    check(holdEmpty === 1'b0, "R3 byte still held", holdEmpty, 0);

    // R12 write while full is ignored
    loadByte(8'hFF);
    txEnable = 1'b1;
    waitStart(found);
    got = '0;
    for (int i = 1; i < 10; i++) nextBit(got[i]);
    check(found && got == asyncFrame(8'h5A), "R12 held byte kept", got, asyncFrame(8'h5A));
    idleBits(12, ones);
    check(ones, "R12 no extra frame", ones, 1);

    // R4 disable mid-character
    loadByte(8'hC3);
    waitStart(found);
    got = '0;
    for (int i = 1; i < 10; i++) begin
      nextBit(got[i]);
      if (i == 3) txEnable = 1'b0;
    end
    check(found && got == asyncFrame(8'hC3), "R4 full char after disable", got, asyncFrame(8'hC3));
    idleBits(8, ones);
    check(ones, "R4 idle after disable", ones, 1);

    // R7 deferred release in asynchronous mode
    txEnable = 1'b1;
    loadByte(8'h81);
    waitStart(found);
    got = '0;
    for (int i = 1; i < 10; i++) begin
      nextBit(got[i]);
      if (i == 2) rtsBit = 1'b0;
      if (i >= 3) check(rtsN === 1'b0, "R7 held during char", rtsN, 0);
    end
    check(got == asyncFrame(8'h81), "R7 frame intact", got, asyncFrame(8'h81));
    nextBit(b);
    @(negedge clk);
    check(rtsN === 1'b1, "R7 released after drain", rtsN, 1);
    rtsBit = 1'b1;

    // R5 break in asynchronous mode
    loadByte(8'h96);
    waitStart(found);
    got = asyncFrame(8'h96);
    nextBit(b);
    sendBreak = 1'b1;
    #1;
    check(txd === 1'b0, "R5 break immediate", txd, 0);
    for (int i = 2; i < 5; i++) begin
      nextBit(b);
      check(b === 1'b0, "R5 break holds", b, 0);
    end
    sendBreak = 1'b0;
    #1;
    check(txd === got[4], "R5 release shows bit", txd, got[4]);
    for (int i = 5; i < 10; i++) begin
      nextBit(b);
      check(b === got[i], "R5 sequence kept", b, got[i]);
    end
    idleBits(4, ones);

    // R8 / R9 / R10 synchronous stream
    txEnable = 1'b0;
    idleBits(4, ones);
    syncMode = 1'b1;
    #1;
    check(rtsN === 1'b0, "R8 follows set", rtsN, 0);
    cur = 8'($urandom());
    loadByte(cur);
    txEnable = 1'b1;
    for (int k = 0; k < 6; k++) begin
      sb = '0;
      nextBit(sb[0]);
      if (k < 5) begin
        nxt = 8'($urandom());
        loadByte(nxt);
      end else begin
        crcStart = 1'b1;
        @(negedge clk);
        crcStart = 1'b0;
      end
      if (k == 2) begin
        rtsBit = 1'b0;
        #1;
        check(rtsN === 1'b1, "R8 follows clear", rtsN, 1);
        rtsBit = 1'b1;
      end
      syncByte(1, sb);
      check(sb == cur, "R9 sync data byte", sb, cur);
      cur = nxt;
    end
    sb = '0;
    syncByte(0, sb);
    check(sb == crcValue[7:0], "R10 check low", sb, crcValue[7:0]);
    sb = '0;
    syncByte(0, sb);
    check(sb == crcValue[15:8], "R10 check high", sb, crcValue[15:8]);
    sb = '0;
    nextBit(sb[0]);
    txEnable = 1'b0;
    syncByte(1, sb);
    check(sb == fillChar, "R9 fill after check", sb, fillChar);
    idleBits(8, ones);
    check(ones, "R3 sync idle when disabled", ones, 1);

    // R11 disable during a check byte
    crcValue = 16'hA500;
    crcStart = 1'b1;
    @(negedge clk);
    crcStart = 1'b0;
    txEnable = 1'b1;
    sb = '0;
    syncByte(5, sb);  // bits 5..7 used as scratch for first three
    sb = {sb[7:5], 5'b0};
    begin
      logic [7:0] rx;
      rx = '0;
      rx[2:0] = sb[7:5];
      txEnable = 1'b0;
      syncByte(3, rx);
      check(rx == {fillChar[7:3], 3'b000}, "R11 fill replaces check", rx, {fillChar[7:3], 3'b000});
    end
    idleBits(10, ones);
    check(ones, "R11 no high check byte", ones, 1);

    // R5 break in synchronous mode
    loadByte(8'h33);
    txEnable = 1'b1;
    nextBit(b);
    check(b === 1'b1, "R9 sync bit0", b, 1);
    nextBit(b);
    sendBreak = 1'b1;
    #1;
    check(txd === 1'b0, "R5 sync break", txd, 0);
    nextBit(b);
    nextBit(b);
    check(b === 1'b0, "R5 sync break holds", b, 0);
    nextBit(b);
    sendBreak = 1'b0;
    #1;
    check(txd === 1'b1, "R5 sync release bit4", txd, 1);
    txEnable = 1'b0;
    sb = 8'h0F;
    syncByte(5, sb);
    check(sb == 8'h2F, "R5 sync sequence kept", sb, 8'h2F);
    idleBits(6, ones);
    check(ones, "R4 sync char completed then idle", ones, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule